// File: doc/BRIEF.md
# Fused Multiply-Add NaN Selector

This block decides which value a fused multiply-add `(a*b)+c` must deliver when the special-value path is taken. It receives a class code for each of the three operands, a flag saying that the product multiplies infinity by zero, and the three raw single-precision operand words. A policy input picks one of five ways to rank the operands. The block then reports three things: which source won (operand a, b, c, or the generated default NaN), whether the invalid-operation flag must be raised, and the finished 32-bit result word. A signaling NaN that wins is returned in its quiet form.

The arithmetic datapath is not part of this block. It sits beside the multiplier and adder and takes over only the NaN and invalid cases. The input side and the output side are each a valid/ready stream. A request moves in when `in_valid` and `in_ready` are both high. A result leaves when `out_valid` and `out_ready` are both high. While a result is waiting and `out_ready` is low, that result holds still and `in_ready` is low, so back-pressure passes straight to the producer. When the register is empty, or is being drained in the same cycle, `in_ready` is high, so one request per cycle can pass at full rate.

Top module: `fma_nan_sel`

## Requirements
- R1: A request accepted at a rising edge appears at that same edge with `out_valid` high. With no accepted request and no stalled result, `out_valid` is low. Reset clears `out_valid`, `out_sel` and `out_invalid`. The selection code is 0 for a, 1 for b, 2 for c and 3 for the default NaN.
- R2: Policy 0 (addend first): inf-times-zero together with a quiet-NaN c selects code 3 with invalid. Otherwise the ranking is signaling c, signaling a, signaling b, quiet c, quiet a, and else b.
- R3: Policy 1 (legacy): inf-times-zero selects code 3 with invalid. Otherwise signaling NaNs win over quiet ones, each scanned a, b, c, and else c.
- R4: Policy 2 (2008 style): inf-times-zero selects c with invalid. Otherwise signaling NaNs win over quiet ones, each scanned c, a, b, and else b.
- R5: Policy 3 always selects code 3. Inf-times-zero raises invalid.
- R6: Policy 4 (first NaN): inf-times-zero selects c with invalid. Otherwise the first NaN in the order a, c, b is chosen, and else b. Policy codes 5 to 7 behave as policy 4.
- R7: Invalid is raised whenever any operand has the signaling class. It is raised in no case other than those listed in R2 to R6.
- R8: The result word is the chosen operand's word, with bit 22 (the fraction MSB) set when that operand is a signaling NaN. Code 3 gives 0x7FC00000.
- R9: While `out_valid` is high and `out_ready` is low, all outputs stay unchanged and `in_ready` is low.
- R10: Class codes are 0 normal, 1 zero, 2 infinity, 3 quiet NaN and 4 signaling NaN. Codes 5 to 7 count as non-NaN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| policy | input | 3 | Ranking policy |
| inf_zero | input | 1 | Product is infinity times zero |
| cls_a | input | 3 | Class of operand a |
| cls_b | input | 3 | Class of operand b |
| cls_c | input | 3 | Class of operand c |
| op_a | input | 32 | Operand a word |
| op_b | input | 32 | Operand b word |
| op_c | input | 32 | Operand c word |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_sel | output | 2 | Winning source code |
| out_invalid | output | 1 | Invalid-operation flag |
| out_word | output | 32 | Result word |

## Verification
The bench uses the default parameters: a 32-bit word with a 23-bit fraction. With these values the quiet bit sits at bit 22 and the default NaN is 0x7FC00000, so every expected word can be written as a plain single-precision constant. At this size every policy can be reached, including codes 5 to 7 and the unused class codes. Each policy gets cases where a signaling and a quiet NaN compete in different operand positions, and cases where inf-times-zero meets a c that is quiet NaN, signaling NaN, or not a NaN at all.

// File: rtl/fns_pkg.sv
`timescale 1ns/1ps
package fns_pkg;

  localparam int NUM_OPS = 3;

  // operand class encodings
  localparam logic [2:0] CLS_NORMAL = 3'd0;
  localparam logic [2:0] CLS_ZERO   = 3'd1;
  localparam logic [2:0] CLS_INF    = 3'd2;
  localparam logic [2:0] CLS_QNAN   = 3'd3;
  localparam logic [2:0] CLS_SNAN   = 3'd4;

  // ranking policies; 5..7 fall back to the first-NaN scheme
  localparam logic [2:0] POL_ADDEND  = 3'd0;
  localparam logic [2:0] POL_LEGACY  = 3'd1;
  localparam logic [2:0] POL_STD2008 = 3'd2;
  localparam logic [2:0] POL_DFLT    = 3'd3;
  localparam logic [2:0] POL_FIRST   = 3'd4;

  typedef enum logic [1:0] {
    PICK_A    = 2'd0,
    PICK_B    = 2'd1,
    PICK_C    = 2'd2,
    PICK_DFLT = 2'd3
  } pick_e;

  typedef struct packed {
    logic [2:0] q;   // quiet NaN per operand, bit0 = a
    logic [2:0] s;   // signaling NaN per operand
  } nan_map_t;

  // Two-tier scan: signaling hits in order o0,o1,o2, then quiet hits in
  // the same order; when nothing hits, the last entry of the order wins.
  function automatic pick_e scan_tiered(input logic [2:0] hi_mask,
                                        input logic [2:0] lo_mask,
                                        input pick_e o0,
                                        input pick_e o1,
                                        input pick_e o2);
    pick_e r;
    if (hi_mask[int'(o0)])      r = o0;
    else if (hi_mask[int'(o1)]) r = o1;
    else if (hi_mask[int'(o2)]) r = o2;
    else if (lo_mask[int'(o0)]) r = o0;
    else if (lo_mask[int'(o1)]) r = o1;
    else                        r = o2;
    return r;
  endfunction

endpackage

// File: rtl/fns_classify.sv
`timescale 1ns/1ps
module fns_classify
  import fns_pkg::*;
#(
  parameter int N = NUM_OPS
) (
  input  logic [N*3-1:0] cls_flat,
  output logic [N-1:0]   is_q,
  output logic [N-1:0]   is_s
);
  for (genvar g = 0; g < N; g++) begin : g_op
    logic [2:0] cls;
    assign cls     = cls_flat[g*3 +: 3];
    assign is_q[g] = (cls == CLS_QNAN);
    assign is_s[g] = (cls == CLS_SNAN);
  end
endmodule

// File: rtl/fns_arbiter.sv
`timescale 1ns/1ps
module fns_arbiter
  import fns_pkg::*;
(
  input  logic [2:0] policy,
  input  logic       inf_zero,
  input  nan_map_t   nan_map,
  output pick_e      sel,
  output logic       invalid
);
  logic [2:0] any_nan;
  logic       snan_seen;
  logic       c_quiet;

  assign any_nan   = nan_map.q | nan_map.s;
  assign snan_seen = |nan_map.s;
  assign c_quiet   = nan_map.q[2];

  always_comb begin
    sel     = PICK_B;
    invalid = snan_seen;
    case (policy)
      POL_ADDEND: begin
        if (inf_zero && c_quiet) begin
          sel     = PICK_DFLT;
          invalid = 1'b1;
        end else begin
          sel = scan_tiered(nan_map.s, nan_map.q, PICK_C, PICK_A, PICK_B);
        end
      end
      POL_LEGACY: begin
        if (inf_zero) begin
          sel     = PICK_DFLT;
          invalid = 1'b1;
        end else begin
          sel = scan_tiered(nan_map.s, nan_map.q, PICK_A, PICK_B, PICK_C);
        end
      end
      POL_STD2008: begin
        if (inf_zero) begin
          sel     = PICK_C;
          invalid = 1'b1;
        end else begin
          sel = scan_tiered(nan_map.s, nan_map.q, PICK_C, PICK_A, PICK_B);
        end
      end
      POL_DFLT: begin
        sel = PICK_DFLT;
        if (inf_zero) invalid = 1'b1;
      end
      default: begin
        if (inf_zero) begin
          sel     = PICK_C;
          invalid = 1'b1;
        end else begin
          sel = scan_tiered(any_nan, any_nan, PICK_A, PICK_C, PICK_B);
        end
      end
    endcase
  end
endmodule

// File: rtl/fns_result.sv
`timescale 1ns/1ps
module fns_result
  import fns_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 23
) (
  input  logic [NUM_OPS*DATA_W-1:0] ops_flat,
  input  logic [NUM_OPS-1:0]        is_s,
  input  pick_e                     sel,
  output logic [DATA_W-1:0]         word
);
  localparam int EXP_W = DATA_W - FRAC_W - 1;
  localparam int QBIT  = FRAC_W - 1;
  localparam logic [DATA_W-1:0] DFLT_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [DATA_W-1:0] quieted [NUM_OPS];

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_quiet
    logic [DATA_W-1:0] raw;
    assign raw = ops_flat[g*DATA_W +: DATA_W];
    always_comb begin
      quieted[g] = raw;
      if (is_s[g]) quieted[g][QBIT] = 1'b1;
    end
  end

  always_comb begin
    case (sel)
      PICK_A:  word = quieted[0];
      PICK_B:  word = quieted[1];
      PICK_C:  word = quieted[2];
      default: word = DFLT_NAN;
    endcase
  end
endmodule

// File: rtl/fns_stage.sv
`timescale 1ns/1ps
module fns_stage #(
  parameter int PAY_W = 35
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic [PAY_W-1:0] up_data,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic [PAY_W-1:0] dn_data
);
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid) dn_data <= up_data;
    end
  end
endmodule

// File: rtl/fma_nan_sel.sv
`timescale 1ns/1ps
module fma_nan_sel
  import fns_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        policy,
  input  logic              inf_zero,
  input  logic [2:0]        cls_a,
  input  logic [2:0]        cls_b,
  input  logic [2:0]        cls_c,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [DATA_W-1:0] op_c,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_sel,
  output logic              out_invalid,
  output logic [DATA_W-1:0] out_word
);
  localparam int PAY_W = 2 + 1 + DATA_W;

  nan_map_t          nmap;
  pick_e             pick;
  logic              inv_c;
  logic [DATA_W-1:0] word_c;
  logic [PAY_W-1:0]  pay_in;
  logic [PAY_W-1:0]  pay_out;

  fns_classify #(.N(NUM_OPS)) u_cls (
    .cls_flat ({cls_c, cls_b, cls_a}),
    .is_q     (nmap.q),
    .is_s     (nmap.s)
  );

  fns_arbiter u_arb (
    .policy   (policy),
    .inf_zero (inf_zero),
    .nan_map  (nmap),
    .sel      (pick),
    .invalid  (inv_c)
  );

  fns_result #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_res (
    .ops_flat ({op_c, op_b, op_a}),
    .is_s     (nmap.s),
    .sel      (pick),
    .word     (word_c)
  );

  assign pay_in = {pick, inv_c, word_c};

  fns_stage #(.PAY_W(PAY_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (pay_in),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (pay_out)
  );

  assign out_sel     = pay_out[PAY_W-1 -: 2];
  assign out_invalid = pay_out[DATA_W];
  assign out_word    = pay_out[DATA_W-1:0];
endmodule

// File: rtl/fma_nan_sel_chk.sv
`timescale 1ns/1ps
module fma_nan_sel_chk #(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 23
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [2:0]        policy,
  input logic              inf_zero,
  input logic [2:0]        cls_a,
  input logic [2:0]        cls_b,
  input logic [2:0]        cls_c,
  input logic              out_valid,
  input logic              out_ready,
  input logic [1:0]        out_sel,
  input logic              out_invalid,
  input logic [DATA_W-1:0] out_word
);
  localparam int EXP_W = DATA_W - FRAC_W - 1;
  localparam logic [DATA_W-1:0] DFLT_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic accept;
  assign accept = in_valid && in_ready;

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !in_valid) |=> !out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_sel) && $stable(out_word) && $stable(out_invalid)));

  p_dflt_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sel == 2'd3) |-> (out_word == DFLT_NAN));

  p_always_dflt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && policy == 3'd3) |=> (out_sel == 2'd3));

  p_snan_inv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (cls_a == 3'd4 || cls_b == 3'd4 || cls_c == 3'd4)) |=> out_invalid);

  p_infzero_c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && policy == 3'd2 && inf_zero) |=> (out_sel == 2'd2 && out_invalid));
endmodule

bind fma_nan_sel fma_nan_sel_chk #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .policy      (policy),
  .inf_zero    (inf_zero),
  .cls_a       (cls_a),
  .cls_b       (cls_b),
  .cls_c       (cls_c),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_sel     (out_sel),
  .out_invalid (out_invalid),
  .out_word    (out_word)
);

// File: tb/sim_fma_nan_sel.sv
`timescale 1ns/1ps
module sim_fma_nan_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  policy = '0;
  logic        inf_zero = 1'b0;
  logic [2:0]  cls_a = '0, cls_b = '0, cls_c = '0;
  logic [31:0] op_a = '0, op_b = '0, op_c = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [1:0]  out_sel;
  logic        out_invalid;
  logic [31:0] out_word;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fma_nan_sel u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .policy(policy), .inf_zero(inf_zero),
    .cls_a(cls_a), .cls_b(cls_b), .cls_c(cls_c),
    .op_a(op_a), .op_b(op_b), .op_c(op_c),
    .out_valid(out_valid), .out_ready(out_ready), .out_sel(out_sel),
    .out_invalid(out_invalid), .out_word(out_word)
  );

  // {policy, inf_zero, cls_a, cls_b, cls_c, exp_sel, exp_inv}
  localparam int NV = 29;
  localparam logic [15:0] VEC [NV] = '{
    {3'd0,1'b1,3'd2,3'd1,3'd3,2'd3,1'b1},
    {3'd0,1'b0,3'd4,3'd3,3'd4,2'd2,1'b1},
    {3'd0,1'b0,3'd3,3'd4,3'd0,2'd1,1'b1},
    {3'd0,1'b0,3'd3,3'd3,3'd3,2'd2,1'b0},
    {3'd0,1'b0,3'd3,3'd3,3'd0,2'd0,1'b0},
    {3'd0,1'b0,3'd0,3'd3,3'd0,2'd1,1'b0},
    {3'd0,1'b1,3'd2,3'd1,3'd4,2'd2,1'b1},
    {3'd0,1'b1,3'd2,3'd1,3'd0,2'd1,1'b0},
    {3'd1,1'b1,3'd1,3'd2,3'd3,2'd3,1'b1},
    {3'd1,1'b0,3'd3,3'd4,3'd4,2'd1,1'b1},
    {3'd1,1'b0,3'd0,3'd3,3'd3,2'd1,1'b0},
    {3'd1,1'b0,3'd0,3'd0,3'd3,2'd2,1'b0},
    {3'd1,1'b0,3'd4,3'd0,3'd4,2'd0,1'b1},
    {3'd2,1'b1,3'd2,3'd1,3'd3,2'd2,1'b1},
    {3'd2,1'b0,3'd4,3'd4,3'd3,2'd0,1'b1},
    {3'd2,1'b0,3'd3,3'd4,3'd0,2'd1,1'b1},
    {3'd2,1'b0,3'd3,3'd3,3'd3,2'd2,1'b0},
    {3'd2,1'b0,3'd0,3'd3,3'd0,2'd1,1'b0},
    {3'd3,1'b1,3'd2,3'd1,3'd0,2'd3,1'b1},
    {3'd3,1'b0,3'd3,3'd0,3'd0,2'd3,1'b0},
    {3'd3,1'b0,3'd4,3'd0,3'd0,2'd3,1'b1},
    {3'd4,1'b1,3'd2,3'd1,3'd3,2'd2,1'b1},
    {3'd4,1'b0,3'd0,3'd3,3'd3,2'd2,1'b0},
    {3'd4,1'b0,3'd3,3'd4,3'd4,2'd0,1'b1},
    {3'd4,1'b0,3'd0,3'd4,3'd0,2'd1,1'b1},
    {3'd5,1'b0,3'd0,3'd3,3'd3,2'd2,1'b0},
    {3'd7,1'b1,3'd1,3'd2,3'd0,2'd2,1'b1},
    {3'd2,1'b0,3'd6,3'd3,3'd7,2'd1,1'b0},   // R10 unused classes
    {3'd4,1'b0,3'd5,3'd0,3'd3,2'd2,1'b0}    // R10 unused classes
  };

  function automatic logic [31:0] word_of(input logic [2:0] cls, input int idx);
    case (cls)
      3'd0:    return 32'h3F800000;
      3'd1:    return 32'h00000000;
      3'd2:    return 32'h7F800000;
      3'd3:    return 32'h7FC00010 + idx;
      3'd4:    return 32'h7F800020 + idx;
      default: return 32'h12345670 + idx;
    endcase
  endfunction

  function automatic string pol_tag(input int i, input logic [2:0] p);
    if (i >= 27) return "R10";
    case (p)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] p, input logic iz,
                       input logic [2:0] a, input logic [2:0] b, input logic [2:0] c);
    policy = p; inf_zero = iz; cls_a = a; cls_b = b; cls_c = c;
    op_a = word_of(a, 0); op_b = word_of(b, 1); op_c = word_of(c, 2);
  endtask

  function automatic logic [31:0] exp_word(input logic [1:0] s, input logic [2:0] a,
                                           input logic [2:0] b, input logic [2:0] c);
    logic [2:0] k;
    logic [31:0] w;
    if (s == 2'd3) return 32'h7FC00000;
    k = (s == 2'd0) ? a : (s == 2'd1) ? b : c;
    w = word_of(k, int'(s));
    if (k == 3'd4) w = w | 32'h00400000;
    return w;
  endfunction

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 reset out_sel", {30'd0, out_sel}, 32'd0);
    check("R1 reset out_invalid", {31'd0, out_invalid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      v = VEC[i];
      drive(v[15:13], v[12], v[11:9], v[8:6], v[5:3]);
      in_valid = 1'b1;
      check("R9 ready when empty", {31'd0, in_ready}, 32'd1);
      @(negedge clk);
      in_valid = 1'b0;
      check("R1 out_valid after accept", {31'd0, out_valid}, 32'd1);
      check(pol_tag(i, v[15:13]), {30'd0, out_sel}, {30'd0, v[2:1]});
      check("R7 invalid", {31'd0, out_invalid}, {31'd0, v[0]});
      check("R8 word", out_word, exp_word(v[2:1], v[11:9], v[8:6], v[5:3]));
    end

    @(negedge clk);
    check("R1 idle out_valid", {31'd0, out_valid}, 32'd0);

    // back-pressure
    out_ready = 1'b0;
    drive(3'd1, 1'b0, 3'd4, 3'd0, 3'd0);
    in_valid = 1'b1;
    @(negedge clk);
    drive(3'd3, 1'b0, 3'd3, 3'd0, 3'd0);
    check("R9 ready low when stalled", {31'd0, in_ready}, 32'd0);
    check("R9 first result sel", {30'd0, out_sel}, 32'd0);
    @(negedge clk);
    check("R9 held valid", {31'd0, out_valid}, 32'd1);
    check("R9 held sel", {30'd0, out_sel}, 32'd0);
    check("R9 held word", out_word, 32'h7FC00020);
    check("R9 held invalid", {31'd0, out_invalid}, 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 second result sel", {30'd0, out_sel}, 32'd3);
    check("R9 second result word", out_word, 32'h7FC00000);
    check("R9 second result invalid", {31'd0, out_invalid}, 32'd0);
    @(negedge clk);
    check("R1 drained", {31'd0, out_valid}, 32'd0);

    // reset in the middle of a held result
    out_ready = 1'b0;
    drive(3'd0, 1'b1, 3'd2, 3'd1, 3'd3);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears valid", {31'd0, out_valid}, 32'd0);
    check("R1 reset clears sel", {30'd0, out_sel}, 32'd0);
    check("R1 reset clears invalid", {31'd0, out_invalid}, 32'd0);
    rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule